// File: doc/BRIEF.md
# Six-Channel DMA Priority Arbiter

This block decides which of six DMA channels owns the transfer engine for the next block of data. Each channel presents a request line, an enable bit and a 2-bit priority level set by software. Whenever the engine is free, the block picks one winner among the channels that are both enabled and requesting. The winner is the channel at the highest level present. When several channels share that level, the one with the lowest index wins.

The winner's grant is registered and held, together with a valid flag, until the transfer engine signals the end of the block. Requests, enables and priority writes that arrive during a block cannot preempt the running channel. The priority levels are captured only at arbitration points: every idle cycle, and the cycle in which the block ends. The grant drops at the edge that ends the block. A fresh arbitration then runs in the following cycle. The data movement itself and the address sequencing of the channels belong to other blocks.

Top module: `dma_prio_arbiter`

## Requirements
- R1: Only a channel whose `ch_en` bit and `ch_req` bit are both 1 can be granted. A disabled channel is never granted, whatever its request or level.
- R2: Each channel's level sits in `ch_prio[2*c+1:2*c]` for channel c. The encoding is 2'b00 low, 2'b01 medium, 2'b10 high and 2'b11 very high. An eligible channel at a higher level always wins over one at a lower level.
- R3: Among eligible channels at the highest level present, the channel with the smallest index is granted.
- R4: `gnt_onehot` has exactly one bit set while `gnt_valid` is 1, and is all zero while `gnt_valid` is 0. Both are 0 after reset.
- R5: While `gnt_valid` is 1 and `blk_done` is 0, the grant stays unchanged at the next edge. This holds even if other channels raise requests, priority levels change, or the granted channel drops its request.
- R6: If `blk_done` is 1 while a grant is valid, `gnt_valid` and `gnt_onehot` are 0 after that edge. In any cycle with no grant and at least one eligible channel, a grant is registered at the next edge.
- R7: The stored priority levels reset to 2'b00. They are loaded from `ch_prio` only at edges ending an idle cycle or a `blk_done` cycle. A level written during a block and restored before `blk_done` has no effect on the next arbitration.
- R8: With no eligible channel, `gnt_valid` stays 0. A `blk_done` pulse while no grant is valid has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_req | input | 6 | Per-channel request lines, bit c for channel c |
| ch_en | input | 6 | Per-channel enable bits |
| ch_prio | input | 12 | Per-channel 2-bit priority levels, channel c in bits [2c+1:2c] |
| blk_done | input | 1 | End of the current data block |
| gnt_onehot | output | 6 | One-hot grant, bit c for channel c |
| gnt_valid | output | 1 | A grant is active |

## Verification
A grant is due one clock edge after an idle cycle in which an eligible request is present. The grant is decided by the priority levels stored at the previous edge, so a level change made while idle needs one extra edge before it counts. After `blk_done` is seen with a valid grant, the grant clears at that same edge and the next winner appears one edge later. The bench drives every input at the falling edge and checks each result at the falling edge that follows the rising edge on which it is due. Before each arbitration it leaves one idle cycle so that newly written levels are already stored.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int ARB_CH_DEF     = 6;
    localparam int ARB_PRIO_W_DEF = 2;

    // Priority level encoding, higher value wins
    typedef enum logic [1:0] {
        PRIO_LOW   = 2'b00,
        PRIO_MED   = 2'b01,
        PRIO_HIGH  = 2'b10,
        PRIO_VHIGH = 2'b11
    } prio_lvl_e;

endpackage

// File: rtl/dma_arb_level_sel.sv
// Keeps only the eligible channels that sit at the highest level present.
module dma_arb_level_sel #(
    parameter int NUM_CH = 6,
    parameter int PRIO_W = 2
) (
    input  logic [NUM_CH-1:0]        elig,
    input  logic [NUM_CH*PRIO_W-1:0] prio,
    output logic [NUM_CH-1:0]        cand
);
    localparam int NUM_LVL = 1 << PRIO_W;

    logic [NUM_LVL-1:0][NUM_CH-1:0] hit;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign hit[l][c] = elig[c] && (prio[c*PRIO_W +: PRIO_W] == PRIO_W'(l));
        end
    end

    // Later (higher) levels override lower ones
    always_comb begin
        cand = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (|hit[l]) cand = hit[l];
        end
    end

endmodule

// File: rtl/dma_arb_first_one.sv
// Picks the lowest-index set bit as a one-hot vector.
module dma_arb_first_one #(
    parameter int W = 6
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] onehot
);
    always_comb begin
        onehot = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = ARB_CH_DEF,
    parameter int PRIO_W = ARB_PRIO_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        ch_req,
    input  logic [NUM_CH-1:0]        ch_en,
    input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
    input  logic                     blk_done,
    output logic [NUM_CH-1:0]        gnt_onehot,
    output logic                     gnt_valid
);
    localparam int PRIO_BITS = NUM_CH * PRIO_W;

    typedef struct packed {
        logic                 busy;
        logic [NUM_CH-1:0]    gnt;
        logic [PRIO_BITS-1:0] prio;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] cand;
    logic [NUM_CH-1:0] pick;
    logic              arb_point;

    assign elig = ch_req & ch_en;

    dma_arb_level_sel #(
        .NUM_CH (NUM_CH),
        .PRIO_W (PRIO_W)
    ) u_level_sel (
        .elig (elig),
        .prio (st_q.prio),
        .cand (cand)
    );

    dma_arb_first_one #(
        .W (NUM_CH)
    ) u_first_one (
        .vec    (cand),
        .onehot (pick)
    );

    // Idle cycles and end-of-block cycles are arbitration points
    assign arb_point = !st_q.busy || blk_done;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (|pick) begin
                st_d.busy = 1'b1;
                st_d.gnt  = pick;
            end
        end else if (blk_done) begin
            st_d.busy = 1'b0;
            st_d.gnt  = '0;
        end
        if (arb_point) begin
            st_d.prio = ch_prio;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_onehot = st_q.gnt;
    assign gnt_valid  = st_q.busy;

endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
    parameter int NUM_CH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_req,
    input logic [NUM_CH-1:0] ch_en,
    input logic              blk_done,
    input logic [NUM_CH-1:0] gnt,
    input logic              valid
);
    // R4
    gnt_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($countones(gnt) == 1));

    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (gnt == '0));

    // R5
    hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !blk_done) |=> (valid && $stable(gnt)));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && blk_done) |=> !valid);

    // R6
    rearb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && ((ch_req & ch_en) != '0)) |=> valid);

    // R1
    eligible_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> ((gnt & $past(ch_req & ch_en)) != '0));

    // R8
    no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && ((ch_req & ch_en) == '0)) |=> !valid);

endmodule

bind dma_prio_arbiter dma_arb_chk #(.NUM_CH(NUM_CH)) u_arb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_req   (ch_req),
    .ch_en    (ch_en),
    .blk_done (blk_done),
    .gnt      (gnt_onehot),
    .valid    (gnt_valid)
);

// File: tb/test_dma_prio_arbiter.sv
`timescale 1ns/1ps
module test_dma_prio_arbiter;
    import dma_arb_pkg::*;

    localparam int NCH = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  ch_req = '0;
    logic [NCH-1:0]  ch_en = '0;
    logic [2*NCH-1:0] ch_prio = '0;
    logic            blk_done = 1'b0;
    logic [NCH-1:0]  gnt_onehot;
    logic            gnt_valid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_prio_arbiter i_dma_prio_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_req     (ch_req),
        .ch_en      (ch_en),
        .ch_prio    (ch_prio),
        .blk_done   (blk_done),
        .gnt_onehot (gnt_onehot),
        .gnt_valid  (gnt_valid)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [NCH-1:0] exp_g);
        logic exp_v;
        exp_v = |exp_g;
        total++;
        if (gnt_onehot !== exp_g || gnt_valid !== exp_v) begin
            bad++;
            $display("FAIL %s: got gnt=%b valid=%b, expected gnt=%b valid=%b",
                     tag, gnt_onehot, gnt_valid, exp_g, exp_v);
        end
    endtask

    // Independent model: highest level first, lowest index within it
    function automatic logic [NCH-1:0] model(input logic [NCH-1:0] r,
                                             input logic [NCH-1:0] e,
                                             input logic [2*NCH-1:0] p);
        for (int lvl = 3; lvl >= 0; lvl--) begin
            for (int c = 0; c < NCH; c++) begin
                if (r[c] && e[c] && p[2*c +: 2] == 2'(lvl)) return NCH'(1) << c;
            end
        end
        return '0;
    endfunction

    task automatic set_prio(input int ch, input prio_lvl_e lvl);
        ch_prio[2*ch +: 2] = lvl;
    endtask

    // Clears requests, ends any block, leaves the arbiter idle
    task automatic go_idle();
        ch_req = '0;
        blk_done = 1'b1;
        tick(1);
        blk_done = 1'b0;
        tick(1);
    endtask

    // Levels must already be stored (one idle edge after writing them)
    task automatic arb(input string tag, input logic [NCH-1:0] r, input logic [NCH-1:0] e);
        ch_req = r;
        ch_en = e;
        tick(1);
        check(tag, model(r, e, ch_prio));
    endtask

    task automatic t_reset();
        tick(3);
        check("R4 reset state", '0);
        ch_prio = '0;
        set_prio(5, PRIO_VHIGH);
        ch_req = '1;
        ch_en = '1;
        rst_n = 1'b1;
        tick(1);
        // stored levels still 00 at first arbitration
        check("R7 reset level low", 6'b000001);
        blk_done = 1'b1;
        tick(1);
        blk_done = 1'b0;
        check("R6 release clears grant", '0);
        tick(1);
        check("R2 very high after rearb", 6'b100000);
        go_idle();
        check("R8 idle after go_idle", '0);
    endtask

    task automatic t_levels();
        ch_prio = '0;
        set_prio(1, PRIO_HIGH);
        set_prio(2, PRIO_MED);
        set_prio(4, PRIO_VHIGH);
        set_prio(5, PRIO_HIGH);
        tick(1);
        arb("R2 very high wins", 6'b111111, '1);
        check("R2 explicit ch4", 6'b010000);
        go_idle();
        arb("R3 high tie ch1 over ch5", 6'b101111, '1);
        check("R3 explicit ch1", 6'b000010);
        go_idle();
        arb("R2 medium over low", 6'b001101, '1);
        check("R2 explicit ch2", 6'b000100);
        go_idle();
    endtask

    task automatic t_ties();
        ch_prio = '0;
        for (int c = 0; c < NCH; c++) set_prio(c, PRIO_MED);
        tick(1);
        arb("R3 tie ch3", 6'b101000, '1);
        check("R3 explicit ch3", 6'b001000);
        go_idle();
        arb("R3 tie ch4", 6'b110000, '1);
        go_idle();
        arb("R3 tie all ch0", 6'b111111, '1);
        check("R3 explicit ch0", 6'b000001);
        go_idle();
    endtask

    task automatic t_enable();
        ch_prio = '0;
        set_prio(0, PRIO_VHIGH);
        tick(1);
        arb("R1 disabled very high skipped", 6'b111111, 6'b100000);
        check("R1 explicit ch5", 6'b100000);
        go_idle();
        ch_req = '0;
        ch_en = '1;
        tick(2);
        check("R8 enabled but no request", '0);
        ch_req = '1;
        ch_en = '0;
        tick(2);
        check("R1 requests all disabled", '0);
        go_idle();
        ch_en = '1;
    endtask

    task automatic t_hold();
        ch_prio = '0;
        tick(1);
        arb("R6 single request", 6'b000100, '1);
        check("R6 explicit ch2", 6'b000100);
        set_prio(5, PRIO_VHIGH);
        ch_req = 6'b100110;
        for (int k = 0; k < 4; k++) begin
            tick(1);
            check("R5 no preempt", 6'b000100);
        end
        ch_req = 6'b100010;
        tick(2);
        check("R5 hold after request drop", 6'b000100);
        blk_done = 1'b1;
        tick(1);
        blk_done = 1'b0;
        check("R6 drop at done", '0);
        tick(1);
        check("R7 level captured at done", 6'b100000);
        go_idle();
    endtask

    task automatic t_revert();
        ch_prio = '0;
        set_prio(1, PRIO_MED);
        tick(1);
        arb("R7 setup ch1", 6'b000010, '1);
        ch_req = 6'b010010;
        set_prio(4, PRIO_VHIGH);
        tick(2);
        set_prio(4, PRIO_LOW);
        tick(1);
        check("R5 held during write", 6'b000010);
        blk_done = 1'b1;
        tick(1);
        blk_done = 1'b0;
        tick(1);
        check("R7 reverted level ignored", 6'b000010);
        go_idle();
    endtask

    task automatic t_idle_done();
        ch_prio = '0;
        ch_req = '0;
        blk_done = 1'b1;
        tick(1);
        blk_done = 1'b0;
        check("R8 done while idle", '0);
        tick(1);
        check("R8 still idle", '0);
        ch_req = 6'b001000;
        tick(1);
        check("R6 grant one edge after request", 6'b001000);
        go_idle();
    endtask

    initial begin
        t_reset();
        t_levels();
        t_ties();
        t_enable();
        t_hold();
        t_revert();
        t_idle_done();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule